// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a synchronous static RAM. It stores 18-bit words as two 9-bit byte lanes and returns read data through a registered pipeline. Every address, data and control input is captured on the rising clock edge. The two exceptions are the output enable, which acts at once, and the burst-order select, which is a static level.

A host begins a burst by pulsing either of two address strobes with the chip selected. The supplied address is loaded, and the first access takes place at that address in the same cycle. While the burst continues, each cycle is another access. The advance input moves a 2-bit counter to the next word of the aligned 4-word block, in linear or interleaved order. Without advance, the same word is accessed again. A cycle with neither write control set is a read. A write can touch lane a, lane b, both lanes, or no lane. Read data appears two rising edges after the access. A strobe taken with the chip deselected ends the burst.

Top module: `burst_sram`

## Requirements
- R1: A cycle with either strobe (`strobeHost` or `strobeCtl`) high and `chipSel` high accesses exactly `addrIn` in that cycle. It restarts the burst counter at zero.
- R2: With `interleave` low, the word offset (address bits [1:0]) after n advances is (start offset + n) mod 4.
- R3: With `interleave` high, the word offset after n advances is start offset XOR (n mod 4).
- R4: A continuing burst cycle with `advance` low accesses the same address as the previous cycle. `advance` has no effect in a cycle where a strobe is high.
- R5: Advancing past the fourth word wraps within the aligned 4-word block. Address bits above bit 1 never change during a burst.
- R6: With `writeEn` high and `globalWr` low, lane a (bits [8:0]) is written only if `byteEn[0]` is high. Lane b (bits [17:9]) is written only if `byteEn[1]` is high. Unselected lanes keep their contents.
- R7: With `globalWr` high, both lanes are written whatever `byteEn` and `writeEn` are.
- R8: A read access at rising edge E shows its word on `dataOut`, with `dataValid` high, from rising edge E+1 until the next edge.
- R9: A read of an address in the cycle right after a write to it returns the newly written data.
- R10: Write cycles, deselected cycles and idle cycles produce no read data. `dataValid` goes low one cycle after the last read data of a burst that was ended by a deselecting strobe.
- R11: When `outEn` is low, `dataValid` is low and `dataOut` is zero at once, with no clock edge needed. Raising `outEn` again brings back the held word.
- R12: After reset, no burst is active and `dataValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrIn | input | ADDR_W | Word address, loaded by a strobe |
| dataIn | input | 18 | Write data, lane b in [17:9], lane a in [8:0] |
| chipSel | input | 1 | Chip select, sampled with a strobe |
| strobeHost | input | 1 | First burst-start strobe |
| strobeCtl | input | 1 | Second burst-start strobe |
| advance | input | 1 | Step the burst counter |
| writeEn | input | 1 | Write enable qualifying the byte enables |
| globalWr | input | 1 | Write both lanes |
| byteEn | input | 2 | Per-lane write enables, bit 0 is lane a |
| outEn | input | 1 | Asynchronous output enable |
| interleave | input | 1 | Static burst order: 0 linear, 1 interleaved |
| dataOut | output | 18 | Read data, zero when not valid |
| dataValid | output | 1 | High when dataOut is driven |

## Verification
The bench builds the block with `ADDR_W` = 6. The whole 64-word array is then small enough to preload through global writes and to mirror word for word in a reference array. Every one of the four start offsets falls in its own 4-word block, so a wrap that leaked into the upper address bits would land on a word holding a different value and be caught. All sixteen combinations of `writeEn`, `globalWr` and `byteEn` are applied to one word, and each result is read back.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int LANE_W  = 9;
  localparam int LANES   = 2;
  localparam int WORD_W  = LANE_W * LANES;
  localparam int BURST_W = 2;

  // Strobes passed from the control to the datapath every cycle
  typedef struct packed {
    logic             rdEn;
    logic [LANES-1:0] laneWr;
  } memStrobe_t;
endpackage

// File: rtl/burst_sram_order.sv
module burst_sram_order
  import burst_sram_pkg::*;
(
  input  logic [BURST_W-1:0] startOff,
  input  logic [BURST_W-1:0] stepCnt,
  input  logic               interleave,
  output logic [BURST_W-1:0] wordOff
);
  logic [BURST_W-1:0] linOff;
  logic [BURST_W-1:0] xorOff;

  assign linOff  = startOff + stepCnt;
  assign xorOff  = startOff ^ stepCnt;
  assign wordOff = interleave ? xorOff : linOff;
endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              chipSel,
  input  logic              strobeHost,
  input  logic              strobeCtl,
  input  logic              advance,
  input  logic              writeEn,
  input  logic              globalWr,
  input  logic [LANES-1:0]  byteEn,
  input  logic              interleave,
  output logic [ADDR_W-1:0] memAddr,
  output memStrobe_t        memStb
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic               active;
  logic [ADDR_W-1:0]  baseAddr;
  logic [BURST_W-1:0] burstCnt;
  logic [BURST_W-1:0] cntNext;
  logic [BURST_W-1:0] startOff;
  logic [BURST_W-1:0] curOff;
  logic [HI_W-1:0]    hiAddr;
  logic               startReq;
  logic               selNow;

  assign startReq = strobeHost | strobeCtl;

  always_comb begin
    if (startReq) begin
      selNow   = chipSel;
      cntNext  = '0;
      startOff = addrIn[BURST_W-1:0];
      hiAddr   = addrIn[ADDR_W-1:BURST_W];
    end else begin
      selNow   = active;
      cntNext  = (active && advance) ? BURST_W'(burstCnt + 1'b1) : burstCnt;
      startOff = baseAddr[BURST_W-1:0];
      hiAddr   = baseAddr[ADDR_W-1:BURST_W];
    end
  end

  burst_sram_order u_order (
    .startOff  (startOff),
    .stepCnt   (cntNext),
    .interleave(interleave),
    .wordOff   (curOff)
  );

  assign memAddr = {hiAddr, curOff};

  // Lane write decode: global write forces every lane
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign memStb.laneWr[l] = selNow & (globalWr | (writeEn & byteEn[l]));
  end
  assign memStb.rdEn = selNow & ~writeEn & ~globalWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      burstCnt <= '0;
      baseAddr <= '0;
    end else begin
      active   <= selNow;
      burstCnt <= cntNext;
      if (startReq) baseAddr <= addrIn;
    end
  end

  p_start_addr_r1: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && chipSel) |-> (memAddr == addrIn));

  p_hold_addr_r4: assert property (@(posedge clk) disable iff (!rstN)
    (active && !startReq && !advance) |-> (memAddr == $past(memAddr)));

  p_wrap_block_r5: assert property (@(posedge clk) disable iff (!rstN)
    (active && !startReq) |->
      (memAddr[ADDR_W-1:BURST_W] == $past(memAddr[ADDR_W-1:BURST_W])));

  p_no_stray_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!writeEn && !globalWr) |-> (memStb.laneWr == '0));

  p_global_lanes_r7: assert property (@(posedge clk) disable iff (!rstN)
    (globalWr && memStb.laneWr != '0) |-> (&memStb.laneWr));
endmodule

// File: rtl/burst_sram_datapath.sv
module burst_sram_datapath
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] memAddr,
  input  memStrobe_t        memStb,
  input  logic [WORD_W-1:0] dataIn,
  output logic [WORD_W-1:0] outWord,
  output logic              outValid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] wrMask;
  logic [WORD_W-1:0] rdStage;
  logic              rdStageValid;

  for (genvar l = 0; l < LANES; l++) begin : g_mask
    assign wrMask[l*LANE_W +: LANE_W] = {LANE_W{memStb.laneWr[l]}};
  end

  // Self-timed write completes at the capturing edge
  always_ff @(posedge clk) begin
    if (|memStb.laneWr)
      mem[memAddr] <= (mem[memAddr] & ~wrMask) | (dataIn & wrMask);
  end

  // Array read stage followed by the output register
  always_ff @(posedge clk) begin
    if (memStb.rdEn) rdStage <= mem[memAddr];
    outWord <= rdStage;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdStageValid <= 1'b0;
      outValid     <= 1'b0;
    end else begin
      rdStageValid <= memStb.rdEn;
      outValid     <= rdStageValid;
    end
  end

  p_read_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    memStb.rdEn |-> ##2 outValid);

  p_no_data_r10: assert property (@(posedge clk) disable iff (!rstN)
    !memStb.rdEn |-> ##2 !outValid);

  p_rw_exclusive_r6: assert property (@(posedge clk) disable iff (!rstN)
    memStb.rdEn |-> (memStb.laneWr == '0));
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [17:0]       dataIn,
  input  logic              chipSel,
  input  logic              strobeHost,
  input  logic              strobeCtl,
  input  logic              advance,
  input  logic              writeEn,
  input  logic              globalWr,
  input  logic [1:0]        byteEn,
  input  logic              outEn,
  input  logic              interleave,
  output logic [17:0]       dataOut,
  output logic              dataValid
);
  logic [ADDR_W-1:0] memAddr;
  memStrobe_t        memStb;
  logic [WORD_W-1:0] outWord;
  logic              outValid;

  burst_sram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .addrIn    (addrIn),
    .chipSel   (chipSel),
    .strobeHost(strobeHost),
    .strobeCtl (strobeCtl),
    .advance   (advance),
    .writeEn   (writeEn),
    .globalWr  (globalWr),
    .byteEn    (byteEn),
    .interleave(interleave),
    .memAddr   (memAddr),
    .memStb    (memStb)
  );

  burst_sram_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .memAddr (memAddr),
    .memStb  (memStb),
    .dataIn  (dataIn),
    .outWord (outWord),
    .outValid(outValid)
  );

  // Output enable acts without a clock; the valid flag stands for the driven bus
  assign dataValid = outValid & outEn;
  assign dataOut   = dataValid ? outWord : '0;

  p_reset_quiet_r12: assert property (@(posedge clk)
    !rstN |=> !dataValid);
endmodule

// File: tb/burst_sram_test.sv
module burst_sram_test;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] addrIn;
  logic [17:0]   dataIn;
  logic          chipSel, strobeHost, strobeCtl, advance;
  logic          writeEn, globalWr, outEn, interleave;
  logic [1:0]    byteEn;
  logic [17:0]   dataOut;
  logic          dataValid;

  always #2.5 clk = ~clk;

  burst_sram #(.ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .dataIn(dataIn),
    .chipSel(chipSel), .strobeHost(strobeHost), .strobeCtl(strobeCtl),
    .advance(advance), .writeEn(writeEn), .globalWr(globalWr),
    .byteEn(byteEn), .outEn(outEn), .interleave(interleave),
    .dataOut(dataOut), .dataValid(dataValid)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [17:0]   refMem [DEPTH];
  bit            mActive = 0;
  logic [AW-1:0] mBase = '0;
  logic [1:0]    mCnt = '0;
  bit            prevV = 0;
  logic [17:0]   prevD = '0;

  task automatic check(string tag, bit gotV, bit expV, logic [17:0] gotD, logic [17:0] expD);
    checks++;
    if (gotV !== expV || (expV && gotD !== expD)) begin
      failures++;
      $display("FAIL %s: valid=%0b data=%h, expected valid=%0b data=%h", tag, gotV, gotD, expV, expD);
    end
  endtask

  // One access cycle: drive at the falling edge, update the model, check the word from the previous access
  task automatic step(bit sh, bit sc, bit sel, bit adv, bit we, bit gw, logic [1:0] be,
                      logic [AW-1:0] a, logic [17:0] d, string tag);
    bit s;
    bit curV = 0;
    logic [17:0] curD = '0;
    logic [1:0] off;
    logic [AW-1:0] ea;
    strobeHost = sh; strobeCtl = sc; chipSel = sel; advance = adv;
    writeEn = we; globalWr = gw; byteEn = be; addrIn = a; dataIn = d;
    if (sh || sc) begin
      s = sel; mBase = a; mCnt = 2'd0;
    end else begin
      s = mActive;
      if (mActive && adv) mCnt = mCnt + 2'd1;
    end
    off = interleave ? (mBase[1:0] ^ mCnt) : (mBase[1:0] + mCnt);
    ea = {mBase[AW-1:2], off};
    if (s) begin
      if (gw) refMem[ea] = d;
      else if (we) begin
        if (be[0]) refMem[ea][8:0] = d[8:0];
        if (be[1]) refMem[ea][17:9] = d[17:9];
      end else begin
        curV = 1; curD = refMem[ea];
      end
    end
    mActive = s;
    @(posedge clk);
    @(negedge clk);
    check(tag, dataValid, prevV, dataOut, prevD);
    prevV = curV; prevD = curD;
  endtask

  task automatic desel(string tag);
    step(1, 0, 0, 0, 0, 0, 2'b00, '0, '0, tag);
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, 0, 2'b00, '0, '0, tag);
  endtask

  task automatic t_reset();
    rstN = 0; chipSel = 0; strobeHost = 0; strobeCtl = 0; advance = 0;
    writeEn = 0; globalWr = 0; byteEn = 0; addrIn = '0; dataIn = '0;
    outEn = 1; interleave = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R12", dataValid, 0, dataOut, '0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < DEPTH; i++)
      step(i[0], !i[0], 1, 0, 0, 1, 2'b00, AW'(i), 18'(i * 4421) ^ 18'h2a5c3, "R7 fill/R10 no read data");
    desel("R10");
    idle("R10");
  endtask

  task automatic t_burst(bit mode);
    string tagOrd;
    desel("R10");
    idle("R10");
    interleave = mode;
    tagOrd = mode ? "R3 interleaved" : "R2 linear";
    for (int off = 0; off < 4; off++) begin
      logic [AW-1:0] a;
      a = AW'(4 * (2 + off) + off);
      step(off[0], !off[0], 1, 0, 0, 0, 2'b00, a, '0, "R1 start");
      for (int k = 0; k < 3; k++) step(0, 0, 0, 1, 0, 0, 2'b00, '0, '0, tagOrd);
      step(0, 0, 0, 1, 0, 0, 2'b00, '0, '0, "R5 wrap");
      step(0, 0, 0, 1, 0, 0, 2'b00, '0, '0, "R5 after wrap");
      step(0, 0, 0, 0, 0, 0, 2'b00, '0, '0, "R4 hold");
      step(1, 0, 1, 1, 0, 0, 2'b00, a, '0, "R4 advance ignored");
      step(0, 0, 0, 1, 0, 0, 2'b00, '0, '0, tagOrd);
      desel("R10");
      idle("R10");
    end
  endtask

  task automatic t_bytes();
    for (int k = 0; k < 16; k++) begin
      bit we, gw;
      logic [1:0] be;
      we = k[3]; gw = k[2]; be = k[1:0];
      step(1, 0, 1, 0, we, gw, be, 6'd40, 18'(k * 9973) ^ 18'h3c0f0,
           gw ? "R7 global" : "R6 byte");
      step(0, 1, 1, 0, 0, 0, 2'b00, 6'd40, '0, "R6 readback");
      step(0, 0, 0, 0, 0, 0, 2'b00, '0, '0, "R7 readback");
      desel("R10");
    end
    idle("R10");
  endtask

  task automatic t_rdAfterWr();
    step(1, 0, 1, 0, 0, 1, 2'b00, 6'd50, 18'h1b2c3, "R9 write");
    step(0, 1, 1, 0, 0, 0, 2'b00, 6'd50, '0, "R9 read next cycle");
    step(0, 0, 0, 0, 1, 0, 2'b10, '0, 18'h2f00d, "R9 in-burst write");
    step(0, 0, 0, 0, 0, 0, 2'b00, '0, '0, "R9 in-burst read");
    desel("R9");
    idle("R9");
    idle("R10");
  endtask

  task automatic t_deselect();
    step(0, 1, 1, 0, 0, 0, 2'b00, 6'd13, '0, "R10 read");
    step(0, 0, 0, 1, 0, 0, 2'b00, '0, '0, "R10 read");
    desel("R10 last word");
    idle("R10 bus inactive");
    idle("R10 stays inactive");
    step(0, 0, 0, 1, 1, 0, 2'b11, '0, '0, "R10 no session");
    idle("R10 no session");
  endtask

  task automatic t_outEn();
    logic [17:0] want;
    want = refMem[5];
    step(1, 0, 1, 0, 0, 0, 2'b00, 6'd5, '0, "R11 read");
    desel("R11 data present");
    outEn = 0;
    #1;
    check("R11 disabled", dataValid, 0, dataOut, '0);
    checks++;
    if (dataOut !== '0) begin
      failures++;
      $display("FAIL R11: dataOut=%h, expected 0", dataOut);
    end
    outEn = 1;
    #1;
    check("R11 re-enabled", dataValid, 1, dataOut, want);
    idle("R11");
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fill();
    t_burst(0);
    t_burst(1);
    t_bytes();
    t_rdAfterWr();
    t_deselect();
    t_outEn();
    done = 1;
    summary();
    $finish;
  end
endmodule